// File: doc/BRIEF.md
# Sampled PID Controller with Setpoint Weighting and Filtered Derivative

This block computes one control output per sample from a setpoint and a process measurement, all in two's-complement fixed point (default 16-bit words with 12 fraction bits). Each sample is started by a one-cycle strobe. The block latches the setpoint, the measurement and the mode select. It then forms a weighted proportional term, an integral term driven by the previous sample's error, and a gain-limited derivative term driven by the change in measurement. It adds the terms that the mode allows, pulses a completion flag for one cycle and goes to sleep until the next strobe.

The five coefficients live in a small register bank written and read at runtime through a chip-select port. All products come from a single sequential unit that recodes one operand bit pair per cycle (radix-2 Booth) and computes two products at once, X·Y + T·Z. It is used three times per sample. The derivative state, the integral state and the previous setpoint and measurement are committed only when a sample completes. In sleep only the coefficient port is active.

Top module: `pidw_core`

## Requirements
- R1: Synchronous active-high reset clears u_out, done, host_rdata, the integral and derivative states, the stored previous setpoint and measurement, and all five coefficients. Each coefficient then reads back as 0.
- R2: Coefficient map: address 0 = setpoint weight A, 1 = measurement weight B, 2 = integral gain C, 3 = derivative pole H, 4 = derivative gain L. A write happens on a cycle with host_cs=1 and host_we=1. A read has host_cs=1 and host_we=0, and host_rdata shows the stored value from the next cycle on. Reads of addresses 5..7 return 0, and writes to them change no coefficient.
- R3: P(k) = (A·sp(k) + B·meas(k)) >>> NF, where >>> is an arithmetic shift, and the result is truncated to UW bits.
- R4: I(k) = I(k-1) + ((C·e(k-1)) >>> NF) modulo 2^UW, with e(k-1) = sp(k-1) − meas(k-1) taken from the previous completed sample. Both start at 0 after reset.
- R5: D(k) = (H·D(k-1) + L·f(k)) >>> NF truncated to UW bits, with f(k) = meas(k) − meas(k-1).
- R6: mode 2'b00 gives u = P. Mode 2'b01 gives u = P + I. Modes 2'b10 and 2'b11 give u = P + I + D. The sum is taken modulo 2^UW. The I and D states advance on every completed sample whatever the mode.
- R7: done is high for exactly one cycle. It rises at the clock edge LAT = 3·UW+7 edges after the edge that samples start (109 with the defaults). u_out takes its new value at that same edge.
- R8: Between done and the next accepted start, u_out, done and the multiply datapath hold their values, even while the host port is active.
- R9: A start that arrives while a sample is in progress is ignored. The sample in progress finishes with its own latched inputs and its original timing.
- R10: UW = 2N+2. The dual product is kept at full width, so the proportional term is exact even with all four operands at the most negative code (A = B = sp = meas = −2^(N−1) gives P = 2^(2N−1−NF)).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle strobe that begins a sample when idle |
| mode | input | 2 | Term select: 00 P, 01 PI, 1x PID |
| sp | input | N | Setpoint, signed Q(N−NF).NF |
| meas | input | N | Process measurement, signed Q(N−NF).NF |
| host_cs | input | 1 | Coefficient port select |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 3 | Coefficient address |
| host_wdata | input | N | Coefficient write data |
| host_rdata | output | N | Coefficient read data, registered |
| u_out | output | UW | Control output, signed, NF fraction bits |
| done | output | 1 | One-cycle completion pulse |

## Verification
The outputs are compared sample by sample with a bench model that carries its own integral, derivative and previous-input state. Directed samples with a single non-zero coefficient isolate each term. Mode sweeps over the same input sequence show that masking affects only the sum and not the state updates. Full-range random coefficients and inputs exercise every Booth digit pattern and the wrap of the state registers. Two directed cases target the recoder's edge: operands at the most negative code, and a second start during a busy sample. The second case separates correct latching from restart or corruption of the sample in progress.

// File: rtl/pidw_pkg.sv
package pidw_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_PROP,
    PH_INTG,
    PH_DERV,
    PH_FIN
  } phase_t;

  localparam int NCOEF = 5;

  // coefficient slots; the host address equals the slot index
  localparam int K_REF   = 0;  // setpoint weight
  localparam int K_MEAS  = 1;  // measurement weight
  localparam int K_INTG  = 2;  // integral gain
  localparam int K_DPOLE = 3;  // derivative pole
  localparam int K_DGAIN = 4;  // derivative gain

  localparam logic [1:0] MODE_P  = 2'b00;
  localparam logic [1:0] MODE_PI = 2'b01;

  function automatic logic mode_has_i(input logic [1:0] m);
    return m != MODE_P;
  endfunction

  function automatic logic mode_has_d(input logic [1:0] m);
    return m[1];
  endfunction

endpackage

// File: rtl/pidw_coef_bank.sv
module pidw_coef_bank
  import pidw_pkg::*;
#(
  parameter int N  = 16,
  parameter int AW = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cs,
  input  logic                       we,
  input  logic [AW-1:0]              addr,
  input  logic [N-1:0]               wdata,
  output logic [N-1:0]               rdata,
  output logic [NCOEF-1:0][N-1:0]    coefs
);

  logic [NCOEF-1:0][N-1:0] bank;
  logic [N-1:0]            rd_mux;

  for (genvar g = 0; g < NCOEF; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)
        bank[g] <= '0;
      else if (cs && we && addr == AW'(g))
        bank[g] <= wdata;
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NCOEF; i++)
      if (addr == AW'(i)) rd_mux = bank[i];
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '0;
    else if (cs && !we)
      rdata <= rd_mux;
  end

  assign coefs = bank;

endmodule

// File: rtl/pidw_booth_dmac.sv
module pidw_booth_dmac #(
  parameter int N  = 16,
  parameter int MW = 34,
  localparam int ACCW = N + MW + 1,
  localparam int CW   = $clog2(MW)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   go,
  input  logic signed [N-1:0]    x,
  input  logic signed [N-1:0]    t,
  input  logic [MW-1:0]          yv,
  input  logic [MW-1:0]          zv,
  output logic                   busy,
  output logic                   vld,
  output logic signed [ACCW-1:0] acc
);

  logic signed [N-1:0] x_r, t_r;
  logic [MW:0]         ysh, zsh;
  logic [CW-1:0]       cnt;

  // pair = {current bit, next lower bit}; digit = lower - current
  function automatic logic signed [ACCW-1:0] booth_term(input logic [1:0] pair,
                                                         input logic signed [N-1:0] m);
    logic signed [ACCW-1:0] me;
    me = {{(ACCW-N){m[N-1]}}, m};
    case (pair)
      2'b01:   return me;
      2'b10:   return -me;
      default: return '0;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      vld  <= 1'b0;
      acc  <= '0;
      cnt  <= '0;
      x_r  <= '0;
      t_r  <= '0;
      ysh  <= '0;
      zsh  <= '0;
    end else begin
      vld <= 1'b0;
      if (go && !busy) begin
        x_r  <= x;
        t_r  <= t;
        ysh  <= {yv, 1'b0};
        zsh  <= {zv, 1'b0};
        acc  <= '0;
        cnt  <= CW'(MW - 1);
        busy <= 1'b1;
      end else if (busy) begin
        acc <= (acc <<< 1) + booth_term(ysh[MW:MW-1], x_r)
                           + booth_term(zsh[MW:MW-1], t_r);
        ysh <= ysh << 1;
        zsh <= zsh << 1;
        if (cnt == '0) begin
          busy <= 1'b0;
          vld  <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/pidw_sequencer.sv
module pidw_sequencer
  import pidw_pkg::*;
#(
  parameter int N  = 16,
  parameter int NF = 12,
  parameter int UW = 34,
  localparam int ACCW = N + UW + 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic [1:0]              mode,
  input  logic [N-1:0]            sp,
  input  logic [N-1:0]            meas,
  input  logic [NCOEF-1:0][N-1:0] coefs,
  input  logic                    vld,
  input  logic signed [ACCW-1:0]  acc,
  output logic                    go,
  output logic signed [N-1:0]     x_op,
  output logic signed [N-1:0]     t_op,
  output logic [UW-1:0]           y_op,
  output logic [UW-1:0]           z_op,
  output logic signed [UW-1:0]    u_out,
  output logic                    done,
  output logic                    busy
);

  phase_t phase;
  logic [1:0]           mode_q;
  logic [N-1:0]         sp_q, meas_q, sp_prev, meas_prev;
  logic signed [UW-1:0] i_st, d_st, p_res, i_new, d_new;
  logic signed [ACCW-1:0] acc_sh;
  logic signed [UW-1:0]   scaled, i_term, d_term;

  function automatic logic signed [UW-1:0] sx(input logic [N-1:0] v);
    return {{(UW-N){v[N-1]}}, v};
  endfunction

  assign acc_sh = acc >>> NF;
  assign scaled = acc_sh[UW-1:0];
  assign busy   = (phase != PH_IDLE);
  assign i_term = mode_has_i(mode_q) ? i_new : '0;
  assign d_term = mode_has_d(mode_q) ? d_new : '0;

  always_comb begin
    x_op = '0;
    t_op = '0;
    y_op = '0;
    z_op = '0;
    case (phase)
      PH_PROP: begin
        x_op = coefs[K_REF];
        t_op = coefs[K_MEAS];
        y_op = sx(sp_q);
        z_op = sx(meas_q);
      end
      PH_INTG: begin
        x_op = coefs[K_INTG];
        y_op = sx(sp_prev) - sx(meas_prev);
      end
      PH_DERV: begin
        x_op = coefs[K_DPOLE];
        t_op = coefs[K_DGAIN];
        y_op = d_st;
        z_op = sx(meas_q) - sx(meas_prev);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      go        <= 1'b0;
      done      <= 1'b0;
      mode_q    <= '0;
      sp_q      <= '0;
      meas_q    <= '0;
      sp_prev   <= '0;
      meas_prev <= '0;
      i_st      <= '0;
      d_st      <= '0;
      p_res     <= '0;
      i_new     <= '0;
      d_new     <= '0;
      u_out     <= '0;
    end else begin
      go   <= 1'b0;
      done <= 1'b0;
      case (phase)
        PH_IDLE: if (start) begin
          mode_q <= mode;
          sp_q   <= sp;
          meas_q <= meas;
          go     <= 1'b1;
          phase  <= PH_PROP;
        end
        PH_PROP: if (vld) begin
          p_res <= scaled;
          go    <= 1'b1;
          phase <= PH_INTG;
        end
        PH_INTG: if (vld) begin
          i_new <= i_st + scaled;
          go    <= 1'b1;
          phase <= PH_DERV;
        end
        PH_DERV: if (vld) begin
          d_new <= scaled;
          phase <= PH_FIN;
        end
        PH_FIN: begin
          u_out     <= p_res + i_term + d_term;
          i_st      <= i_new;
          d_st      <= d_new;
          sp_prev   <= sp_q;
          meas_prev <= meas_q;
          done      <= 1'b1;
          phase     <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pidw_core.sv
module pidw_core
  import pidw_pkg::*;
#(
  parameter int N  = 16,
  parameter int NF = 12,
  parameter int AW = 3,
  localparam int UW   = 2 * N + 2,
  localparam int ACCW = N + UW + 1,
  localparam int LAT  = 3 * UW + 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [1:0]    mode,
  input  logic [N-1:0]  sp,
  input  logic [N-1:0]  meas,
  input  logic          host_cs,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [N-1:0]  host_wdata,
  output logic [N-1:0]  host_rdata,
  output logic [UW-1:0] u_out,
  output logic          done
);

  logic [NCOEF-1:0][N-1:0] coefs;
  logic                    go, vld, busy, mac_busy;
  logic signed [N-1:0]     x_op, t_op;
  logic [UW-1:0]           y_op, z_op;
  logic signed [ACCW-1:0]  dmac_acc;
  logic signed [UW-1:0]    u_s;

  pidw_coef_bank #(.N(N), .AW(AW)) u_bank (
    .clk(clk), .rst(rst), .cs(host_cs), .we(host_we), .addr(host_addr),
    .wdata(host_wdata), .rdata(host_rdata), .coefs(coefs)
  );

  pidw_booth_dmac #(.N(N), .MW(UW)) u_dmac (
    .clk(clk), .rst(rst), .go(go), .x(x_op), .t(t_op), .yv(y_op), .zv(z_op),
    .busy(mac_busy), .vld(vld), .acc(dmac_acc)
  );

  pidw_sequencer #(.N(N), .NF(NF), .UW(UW)) u_seq (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .sp(sp), .meas(meas),
    .coefs(coefs), .vld(vld), .acc(dmac_acc), .go(go),
    .x_op(x_op), .t_op(t_op), .y_op(y_op), .z_op(z_op),
    .u_out(u_s), .done(done), .busy(busy)
  );

  assign u_out = u_s;

endmodule

// File: rtl/pidw_core_chk.sv
module pidw_core_chk #(
  parameter int UW   = 34,
  parameter int ACCW = 51,
  parameter int LAT  = 109
) (
  input logic            clk,
  input logic            rst,
  input logic            start,
  input logic            busy,
  input logic            done,
  input logic [UW-1:0]   u,
  input logic [ACCW-1:0] acc
);

  int unsigned cnt;

  always_ff @(posedge clk) begin
    if (rst)                cnt <= 0;
    else if (start && !busy) cnt <= 1;
    else if (done)          cnt <= 0;
    else if (cnt != 0)      cnt <= cnt + 1;
  end

  // R7: one-cycle completion pulse
  p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7 / R9: completion lands LAT edges after the accepted start, never restarted
  p_done_latency_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> (cnt == LAT + 1));

  // R7: an accepted start makes the core busy
  p_start_accept_r7: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  // R8: output changes only with the completion pulse
  p_u_holds_r8: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(u));

  // R8: multiply datapath frozen while asleep
  p_sleep_frozen_r8: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> $stable(acc));

endmodule

bind pidw_core pidw_core_chk #(.UW(UW), .ACCW(ACCW), .LAT(LAT)) i_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .u(u_out), .acc(dmac_acc)
);

// File: tb/test_pidw_core.sv
`timescale 1ns/1ps
module test_pidw_core;

  localparam int N   = 16;
  localparam int NF  = 12;
  localparam int UW  = 2 * N + 2;
  localparam int LAT = 3 * UW + 7;
  localparam int SH  = 64 - UW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [1:0]    mode = '0;
  logic [N-1:0]  sp = '0, meas = '0;
  logic          host_cs = 1'b0, host_we = 1'b0;
  logic [2:0]    host_addr = '0;
  logic [N-1:0]  host_wdata = '0;
  logic [N-1:0]  host_rdata;
  logic [UW-1:0] u_out;
  logic          done;

  int checks = 0;
  int failures = 0;

  longint ka [5];
  longint st_i = 0, st_d = 0, sp_p = 0, me_p = 0;

  always #2 clk = ~clk;

  pidw_core i_pidw_core (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .sp(sp), .meas(meas),
    .host_cs(host_cs), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .u_out(u_out), .done(done)
  );

  function automatic longint wrapu(input longint v);
    return (v <<< SH) >>> SH;
  endfunction

  function automatic longint s16(input logic [N-1:0] v);
    return longint'($signed(v));
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [2:0] a, input logic [N-1:0] d);
    @(negedge clk);
    host_cs = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_cs = 1'b0; host_we = 1'b0;
    if (a < 5) ka[a] = s16(d);
  endtask

  task automatic host_read(input logic [2:0] a, output logic [N-1:0] d);
    @(negedge clk);
    host_cs = 1'b1; host_we = 1'b0; host_addr = a;
    @(negedge clk);
    host_cs = 1'b0;
    d = host_rdata;
  endtask

  task automatic run_sample(input logic [1:0] m, input logic [N-1:0] a_sp,
                            input logic [N-1:0] a_me, input bit poke, input string req);
    longint e, f, p, inew, dnew, uexp;
    int n;
    e    = sp_p - me_p;
    f    = s16(a_me) - me_p;
    p    = wrapu((ka[0] * s16(a_sp) + ka[1] * s16(a_me)) >>> NF);
    inew = wrapu(st_i + ((ka[2] * e) >>> NF));
    dnew = wrapu((ka[3] * st_d + ka[4] * f) >>> NF);
    uexp = wrapu(p + ((m != 2'b00) ? inew : 0) + (m[1] ? dnew : 0));
    @(negedge clk);
    mode = m; sp = a_sp; meas = a_me; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    sp = N'($urandom); meas = N'($urandom); mode = 2'($urandom);
    n = 1;
    while (!done && n < 1000) begin
      start = (poke && n == 20);
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    chk({req, " R7 latency"}, n, LAT + 1);
    chk({req, " u"}, wrapu(longint'(u_out)), uexp);
    @(negedge clk);
    chk("R7 done width", longint'(done), 0);
    st_i = inew; st_d = dnew; sp_p = s16(a_sp); me_p = s16(a_me);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=expired expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [N-1:0] rd;
    logic [UW-1:0] u_hold;
    for (int i = 0; i < 5; i++) ka[i] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    chk("R1 u", longint'(u_out), 0);
    chk("R1 done", longint'(done), 0);
    for (int i = 0; i < 5; i++) begin
      host_read(3'(i), rd);
      chk("R1 coef", longint'(rd), 0);
    end

    // R2: map, readback, unmapped access
    host_write(3'd0, 16'h0975);
    host_write(3'd1, 16'hF68B);
    host_write(3'd2, 16'h01CF);
    host_write(3'd3, 16'h02F0);
    host_write(3'd4, 16'hEEA0);
    for (int i = 0; i < 5; i++) begin
      host_read(3'(i), rd);
      chk("R2 readback", s16(rd), ka[i]);
    end
    host_write(3'd5, 16'h7777);
    host_write(3'd7, 16'h1234);
    host_read(3'd6, rd);
    chk("R2 unmapped read", longint'(rd), 0);
    for (int i = 0; i < 5; i++) begin
      host_read(3'(i), rd);
      chk("R2 unmapped write ignored", s16(rd), ka[i]);
    end

    // R3/R4/R5: directed steps
    run_sample(2'b10, 16'h1000, 16'h0000, 1'b0, "R3");
    run_sample(2'b10, 16'h1000, 16'h0400, 1'b0, "R4");
    run_sample(2'b11, 16'h1000, 16'h0800, 1'b0, "R5");
    // R6: modes mask only the sum; state keeps advancing
    run_sample(2'b00, 16'h2000, 16'h0C00, 1'b0, "R6 P");
    run_sample(2'b01, 16'h2000, 16'h1000, 1'b0, "R6 PI");
    run_sample(2'b10, 16'hE000, 16'h1400, 1'b0, "R6 PID");

    // R9: second start while busy is ignored
    run_sample(2'b11, 16'h0800, 16'hF000, 1'b1, "R9");

    // R8: sleep holds output while host port toggles
    u_hold = u_out;
    for (int i = 0; i < 10; i++) begin
      sp = N'($urandom); meas = N'($urandom);
      host_read(3'(i % 5), rd);
    end
    chk("R8 u held", longint'(u_out), longint'(u_hold));
    chk("R8 done low", longint'(done), 0);
    run_sample(2'b10, 16'h0100, 16'h0200, 1'b0, "R8 state kept");

    // R10: most negative operands
    host_write(3'd0, 16'h8000);
    host_write(3'd1, 16'h8000);
    run_sample(2'b00, 16'h8000, 16'h8000, 1'b0, "R10");
    chk("R10 exact P", wrapu(longint'(u_out)), 64'sd524288);

    // random mix, coefficients refreshed while idle
    for (int k = 0; k < 40; k++) begin
      if (k % 8 == 0)
        for (int j = 0; j < 5; j++) host_write(3'(j), N'($urandom));
      run_sample(2'($urandom), N'($urandom), N'($urandom), (k % 7 == 3),
                 "R3 R4 R5 R6 random");
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule